// File: doc/BRIEF.md
# RNS Modular Product and CRT Reconstruction Unit

This unit is the back half of a residue-number-system multiplier. It works on the moduli 17, 5, 4 and 3, which are pairwise coprime and give a dynamic range of 1020. Each operand arrives as four residue fields, one per modulus, with a single valid strobe. A front end with one lane per modulus forms the product of the two residues in that lane and reduces it modulo the lane's modulus. The four lane products are registered. The reconstruction stage then scales each product by a fixed constant and adds the four terms. It brings the total into the range [0, 1020) and registers the result as a 10-bit binary integer.

Each scale constant is 1020/m multiplied by the inverse of (1020/m) modulo m. The constants are 340 for modulus 3, 765 for modulus 4, 816 for modulus 5 and 120 for modulus 17. The scaled sum never exceeds 8159. Three conditional subtractions, of 4080, 2040 and 1020 in that order, bring it below 1020. An upstream forward converter supplies the residues. When the product of the two original operands is 1020 or more, the result wraps modulo 1020, and this wrap is the defined behaviour.

Top module: `rns_crt_mul`

## Requirements
- R1: A result appears on `out_valid`/`out_value` after the second rising clock edge following the edge that samples `in_valid` high. `out_valid` is high in the cycle after every cycle in which the internal product stage holds valid data.
- R2: `out_value` is always below 1020.
- R3: Lane k computes (a_k·b_k) mod m_k for m = 3 (`*_m3`, 2 bits), 4 (`*_m4`, 2 bits), 5 (`*_m5`, 3 bits) and 17 (`*_m17`, 5 bits). Every input residue must be below its modulus.
- R4: When no new result is produced, `out_value` keeps its last value and `out_valid` stays low, even if the residue inputs change while `in_valid` is low.
- R5: Every valid output, reduced modulo each m_k, equals the lane-k product registered one cycle earlier.
- R6: When the second operand's residues all encode 1, the output equals the integer whose residues were applied, for every integer from 0 to 1019.
- R7: When the true product of the two operands is below 1020, the output equals that product.
- R8: When the true product is 1020 or more, the output equals the product mod 1020.
- R9: Inputs presented on consecutive cycles produce one result per cycle, in the same order.
- R10: An active-low reset clears `out_valid` and `out_value` to 0, both at start-up and when applied in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand residues are valid this cycle |
| a_m3 | input | 2 | Operand A residue mod 3 |
| a_m4 | input | 2 | Operand A residue mod 4 |
| a_m5 | input | 3 | Operand A residue mod 5 |
| a_m17 | input | 5 | Operand A residue mod 17 |
| b_m3 | input | 2 | Operand B residue mod 3 |
| b_m4 | input | 2 | Operand B residue mod 4 |
| b_m5 | input | 3 | Operand B residue mod 5 |
| b_m17 | input | 5 | Operand B residue mod 17 |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_value | output | 10 | Reconstructed binary result, 0 to 1019 |

## Verification
The identity pattern applies every integer in the range as operand A with B set to one. Any wrong scale constant or faulty reduction step then shows up as a mismatch at specific values.

A vector table of hand-picked pairs covers several cases. Zero operands test the lower edge. Products just below 1020 exercise the deepest subtraction path. Products at or above 1020 separate the exact-product case from the wrapping case. Random pairs with products below 1020 confirm general multiplication. Back-to-back issue shows whether results keep their order at full rate. Idle cycles in which the residue inputs change show whether the output register holds.

// File: rtl/rns_crt_pkg.sv
package rns_crt_pkg;

  // number of residue lanes and the widest residue field
  localparam int NCH = 4;
  localparam int RW  = 5;

  // dynamic range (product of all moduli) and output width
  localparam int M_RANGE = 1020;
  localparam int OUT_W   = $clog2(M_RANGE);

  typedef logic [RW-1:0]     res_t;
  typedef res_t [NCH-1:0]    res_vec_t;

  // lane moduli, lane 0 first
  function automatic int modulus(input int lane);
    case (lane)
      0:       return 3;
      1:       return 4;
      2:       return 5;
      default: return 17;
    endcase
  endfunction

  // inverse of (M_RANGE / m) modulo m, per lane
  function automatic int inv_of_cofactor(input int lane);
    case (lane)
      0:       return 1;
      1:       return 3;
      2:       return 4;
      default: return 2;
    endcase
  endfunction

  // scale constant applied to the lane product before summation
  function automatic int crt_weight(input int lane);
    return (M_RANGE / modulus(lane)) * inv_of_cofactor(lane);
  endfunction

  // largest possible weighted sum
  function automatic int max_weighted_sum();
    int acc;
    acc = 0;
    for (int i = 0; i < NCH; i++) acc += crt_weight(i) * (modulus(i) - 1);
    return acc;
  endfunction

  localparam int SUM_W     = $clog2(max_weighted_sum() + 1);
  localparam int RED_STEPS = $clog2(max_weighted_sum() / M_RANGE + 1);

  // modular product of two residues below m
  function automatic res_t mod_mul(input res_t a, input res_t b, input int m);
    logic [2*RW-1:0] prod;
    logic [2*RW-1:0] mm;
    prod = {{RW{1'b0}}, a} * {{RW{1'b0}}, b};
    mm   = (2*RW)'(m);
    return res_t'(prod % mm);
  endfunction

endpackage

// File: rtl/rns_chan_mul.sv
module rns_chan_mul
  import rns_crt_pkg::*;
#(
  parameter int MOD = 3
) (
  input  res_t a,
  input  res_t b,
  output res_t p
);

  always_comb p = mod_mul(a, b, MOD);

endmodule

// File: rtl/rns_crt_sum.sv
module rns_crt_sum
  import rns_crt_pkg::*;
(
  input  res_vec_t         prod,
  output logic [SUM_W-1:0] remainder
);

  logic [SUM_W-1:0] wsum;

  always_comb begin
    wsum = '0;
    for (int i = 0; i < NCH; i++)
      wsum = wsum + SUM_W'(crt_weight(i)) * SUM_W'(prod[i]);
  end

  // binary-weighted conditional subtraction: M*2^(k) for k high to low
  logic [SUM_W-1:0] stage [RED_STEPS+1];

  assign stage[RED_STEPS] = wsum;

  for (genvar k = RED_STEPS - 1; k >= 0; k--) begin : g_reduce
    localparam logic [SUM_W-1:0] SUBV = SUM_W'(M_RANGE << k);
    assign stage[k] = (stage[k+1] >= SUBV) ? stage[k+1] - SUBV : stage[k+1];
  end

  assign remainder = stage[0];

endmodule

// File: rtl/rns_crt_mul.sv
module rns_crt_mul
  import rns_crt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       a_m3,
  input  logic [1:0]       a_m4,
  input  logic [2:0]       a_m5,
  input  logic [4:0]       a_m17,
  input  logic [1:0]       b_m3,
  input  logic [1:0]       b_m4,
  input  logic [2:0]       b_m5,
  input  logic [4:0]       b_m17,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_value
);

  res_vec_t a_vec, b_vec;
  res_vec_t chan_prod;   // combinational lane products
  res_vec_t prod_q;      // registered lane products
  logic     s1_valid;
  logic [SUM_W-1:0] rem_full;

  assign a_vec = {RW'(a_m17), RW'(a_m5), RW'(a_m4), RW'(a_m3)};
  assign b_vec = {RW'(b_m17), RW'(b_m5), RW'(b_m4), RW'(b_m3)};

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    rns_chan_mul #(.MOD(modulus(g))) u_mul (
      .a (a_vec[g]),
      .b (b_vec[g]),
      .p (chan_prod[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      prod_q   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) prod_q <= chan_prod;
    end
  end

  rns_crt_sum u_sum (
    .prod      (prod_q),
    .remainder (rem_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_value <= rem_full[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/rns_crt_mul_chk.sv
module rns_crt_mul_chk
  import rns_crt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             s1_valid,
  input res_vec_t         prod_q,
  input logic [SUM_W-1:0] rem_full,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_value
);

  p_out_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s1_valid));

  p_out_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_value) < M_RANGE));

  p_rem_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (int'(rem_full) < M_RANGE));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> ($stable(out_value) && !out_valid));

  for (genvar g = 0; g < NCH; g++) begin : g_lane_chk
    p_lane_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> (int'(prod_q[g]) < modulus(g)));

    p_crt_consistent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((int'(out_value) % modulus(g)) == int'($past(prod_q[g]))));
  end

endmodule

bind rns_crt_mul rns_crt_mul_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s1_valid  (s1_valid),
  .prod_q    (prod_q),
  .rem_full  (rem_full),
  .out_valid (out_valid),
  .out_value (out_value)
);

// File: tb/rns_crt_mul_test.sv
module rns_crt_mul_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] a_m3 = '0, a_m4 = '0, b_m3 = '0, b_m4 = '0;
  logic [2:0] a_m5 = '0, b_m5 = '0;
  logic [4:0] a_m17 = '0, b_m17 = '0;
  logic       out_valid;
  logic [9:0] out_value;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rns_crt_mul uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_m3(a_m3), .a_m4(a_m4), .a_m5(a_m5), .a_m17(a_m17),
    .b_m3(b_m3), .b_m4(b_m4), .b_m5(b_m5), .b_m17(b_m17),
    .out_valid(out_valid), .out_value(out_value)
  );

  // pairs {a, b, expected}: expected is the product folded into [0,1020)
  localparam int NVEC = 10;
  localparam int VEC [NVEC][3] = '{
    '{12,   2,    24},
    '{0,    999,  0},
    '{1,    1019, 1019},
    '{31,   32,   992},
    '{6,    7,    42},
    '{33,   31,   3},
    '{40,   30,   180},
    '{17,   60,   0},
    '{1019, 1019, 1},
    '{255,  4,    0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_a(input int x);
    a_m3 = 2'(x % 3); a_m4 = 2'(x % 4); a_m5 = 3'(x % 5); a_m17 = 5'(x % 17);
  endtask

  task automatic set_b(input int x);
    b_m3 = 2'(x % 3); b_m4 = 2'(x % 4); b_m5 = 3'(x % 5); b_m17 = 5'(x % 17);
  endtask

  // one isolated operation; result sampled after two rising edges
  task automatic run_op(input int a, input int b, output bit v, output int y);
    @(negedge clk); set_a(a); set_b(b); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); v = out_valid; y = int'(out_value);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bit v;
    int y;
    int r0, r1;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 reset valid", int'(out_valid), 0);
    check(out_value == 10'd0, "R10 reset value", int'(out_value), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7/R8: vector table
    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][0], VEC[i][1], v, y);
      check(v == 1'b1, "R1 valid after table op", int'(v), 1);
      check(y == VEC[i][2], (VEC[i][0] * VEC[i][1] < 1020) ? "R7 table product" : "R8 table wrap",
            y, VEC[i][2]);
    end

    // R6: identity sweep over the whole range
    for (int x = 0; x < 1020; x++) begin
      run_op(x, 1, v, y);
      check(v && (y == x), "R6 identity sweep", y, x);
    end

    // R7: random pairs with product below range
    for (int i = 0; i < 200; i++) begin
      int a, b;
      a = int'($urandom_range(1, 1019));
      b = int'($urandom_range(0, 1019 / a));
      run_op(a, b, v, y);
      check(v && (y == a * b), "R7 random product", y, a * b);
    end

    // R8: random pairs with product at or above range
    for (int i = 0; i < 50; i++) begin
      int a, b;
      a = int'($urandom_range(32, 1019));
      b = int'($urandom_range(1020 / a + 1, 1019));
      run_op(a, b, v, y);
      check(v && (y == (a * b) % 1020), "R8 random wrap", y, (a * b) % 1020);
    end

    // R4: hold while idle with changing inputs
    run_op(23, 41, v, y);
    check(y == 943, "R7 before hold", y, 943);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); set_a(100 + i); set_b(7 + i);
      check(out_valid == 1'b0, "R4 idle valid low", int'(out_valid), 0);
      check(int'(out_value) == 943, "R4 idle value held", int'(out_value), 943);
    end

    // R9: back-to-back issue
    @(negedge clk); set_a(10); set_b(11); in_valid = 1'b1;
    @(negedge clk); set_a(20); set_b(30);
    @(negedge clk); set_a(50); set_b(19);
    r0 = int'(out_value);
    check(out_valid && (r0 == 110), "R9 back-to-back first", r0, 110);
    @(negedge clk); in_valid = 1'b0;
    r1 = int'(out_value);
    check(out_valid && (r1 == 600), "R9 back-to-back second", r1, 600);
    @(negedge clk);
    check(out_valid && (int'(out_value) == 950), "R9 back-to-back third", int'(out_value), 950);
    @(negedge clk);
    check(out_valid == 1'b0, "R4 strobe ends", int'(out_valid), 0);

    // R10: reset in the middle of operation
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R10 mid reset valid", int'(out_valid), 0);
    check(out_value == 10'd0, "R10 mid reset value", int'(out_value), 0);
    @(negedge clk); rst_n = 1'b1;
    run_op(3, 5, v, y);
    check(v && (y == 15), "R7 after reset", y, 15);

    finish_run();
  end

endmodule